// File: doc/BRIEF.md
# Lock-Gated Dual-Clock Loopback FIFO

This block carries 20-bit parallel video words from a receive clock domain to a transmit clock domain in a parallel loopback path. On the receive clock it stores each decoded word that the receiver marks valid, but only while the receiver reports lock. On the transmit clock it holds off reading until the stored level first reaches half the depth. It then pops one word per transmit clock and passes it on, unchanged, to the re-encoding path. Holding off until half full gives the path margin against the small rate difference between the two clocks.

The write and read pointers cross between the domains in Gray code through multi-flop synchronizers. The lock indication crosses into the read domain the same way. When lock is lost, writing stops and the read side drops its started state. Reading therefore resumes only after the level climbs back to half. A write into a full store is dropped, and a read attempted on an empty store is suppressed. Each of these events sets a sticky flag. Each domain has its own synchronous reset.

Top module: `lbf_top`

## Requirements
- R1: A word on `wr_word` is stored at a write-clock edge only when both `rx_locked` and `wr_valid` are 1; while `rx_locked` is 0, no word enters the store.
- R2: The read side pops nothing until the level it sees (write pointer synchronized into the read domain, minus its read pointer) has reached DEPTH/2 at least once since the last reset or lock loss.
- R3: Once started, the read side pops one word per read clock while the store is not empty. Each popped word is driven on `rd_word` with `rd_valid` high in the cycle after the pop. Words leave in write order, bit for bit unchanged.
- R4: While the synchronized lock is 0, no word is popped and the started state clears. After lock returns, popping resumes only once the level is again at least DEPTH/2.
- R5: A write attempted (locked and valid) while `wr_full` is 1 is dropped without moving the write pointer, and it sets `wr_overflow`. `wr_overflow` stays 1 until `wr_rst`.
- R6: A read attempted (started and locked) while `rd_empty` is 1 is suppressed, and it sets `rd_underflow`. `rd_underflow` stays 1 until `rd_rst`.
- R7: `rd_empty` is 1 when the read-domain level is 0, and `rd_half` is 1 when that level is at least DEPTH/2. `wr_full` is 1 when the write-domain level equals DEPTH.
- R8: `wr_rst` clears the write pointer and `wr_overflow`. `rd_rst` clears the read pointer, the started state, `rd_underflow` and `rd_valid`. After both resets: `rd_empty`=1, `rd_half`=0, `wr_full`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Receive (write) clock |
| wr_rst | input | 1 | Synchronous reset, write domain |
| rx_locked | input | 1 | Receiver lock indication (write domain) |
| wr_valid | input | 1 | Receive word valid |
| wr_word | input | WIDTH | Decoded receive word |
| wr_full | output | 1 | Store full, write-domain view |
| wr_overflow | output | 1 | Sticky: write dropped while full |
| rd_clk | input | 1 | Transmit parallel (read) clock |
| rd_rst | input | 1 | Synchronous reset, read domain |
| rd_word | output | WIDTH | Word toward the transmit encoder |
| rd_valid | output | 1 | `rd_word` carries a popped word |
| rd_empty | output | 1 | Store empty, read-domain view |
| rd_half | output | 1 | Level at least DEPTH/2, read-domain view |
| rd_underflow | output | 1 | Sticky: read suppressed while empty |

## Verification
A start state stuck high would let words out before half full. It would show as `rd_valid` pulses within a few read clocks of the first write, which is checked by sweeping every burst length from zero to the full depth. A start state that failed to clear on lock loss would let a short burst written after relock drain at once, instead of waiting for the half mark. A pointer or Gray conversion error would show as out-of-order or missing words in the sequence checked at `rd_word`. It would also show as flags that disagree with the arithmetic level, within the synchronizer delay of two or three read clocks.

// File: rtl/lbf_pkg.sv
package lbf_pkg;
   function automatic logic [31:0] to_gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic logic [31:0] from_gray(input logic [31:0] g);
      logic [31:0] b;
      b[31] = g[31];
      for (int i = 30; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction
endpackage

// File: rtl/lbf_sync.sv
module lbf_sync #(
   parameter int W      = 1,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] st [STAGES];

   always_ff @(posedge clk) begin
      if (rst) st[0] <= '0;
      else     st[0] <= d;
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) st[i] <= '0;
         else     st[i] <= st[i-1];
      end
   end

   assign q = st[STAGES-1];
endmodule

// File: rtl/lbf_store.sv
module lbf_store #(
   parameter int WIDTH = 20,
   parameter int AW    = 6
) (
   input  logic             wclk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [WIDTH-1:0] wdata,
   input  logic             rclk,
   input  logic             re,
   input  logic [AW-1:0]    raddr,
   output logic [WIDTH-1:0] rdata
);
   localparam int DEPTH = 1 << AW;
   logic [WIDTH-1:0] mem [DEPTH];

   always_ff @(posedge wclk) begin
      if (we) mem[waddr] <= wdata;
   end

   always_ff @(posedge rclk) begin
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/lbf_wr_side.sv
module lbf_wr_side #(
   parameter int AW = 6
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        locked,
   input  logic        valid,
   input  logic [AW:0] rd_gray_s,
   output logic [AW:0] ptr_bin,
   output logic [AW:0] ptr_gray,
   output logic        we,
   output logic        full,
   output logic        overflow
);
   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic [31:0]   rd_bin_w;
   logic [PW-1:0] rd_bin_s, used, nxt_bin;
   logic [31:0]   nxt_gray_w;
   logic          attempt;

   assign rd_bin_w   = lbf_pkg::from_gray(32'(rd_gray_s));
   assign rd_bin_s   = rd_bin_w[PW-1:0];
   assign used       = ptr_bin - rd_bin_s;
   assign full       = (used == PW'(DEPTH));
   assign attempt    = locked && valid;
   assign we         = attempt && !full;
   assign nxt_bin    = ptr_bin + 1'b1;
   assign nxt_gray_w = lbf_pkg::to_gray(32'(nxt_bin));

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_bin  <= '0;
         ptr_gray <= '0;
         overflow <= 1'b0;
      end else begin
         if (we) begin
            ptr_bin  <= nxt_bin;
            ptr_gray <= nxt_gray_w[PW-1:0];
         end
         if (attempt && full) overflow <= 1'b1;
      end
   end
endmodule

// File: rtl/lbf_rd_side.sv
module lbf_rd_side #(
   parameter int AW = 6
) (
   input  logic        clk,
   input  logic        rst,
   input  logic        lock_s,
   input  logic [AW:0] wr_gray_s,
   output logic [AW:0] ptr_bin,
   output logic [AW:0] ptr_gray,
   output logic        take,
   output logic        valid,
   output logic        started,
   output logic        empty,
   output logic        half,
   output logic        underflow
);
   localparam int PW    = AW + 1;
   localparam int DEPTH = 1 << AW;

   logic [31:0]   wr_bin_w;
   logic [PW-1:0] wr_bin_s, level, nxt_bin;
   logic [31:0]   nxt_gray_w;
   logic          attempt;

   assign wr_bin_w   = lbf_pkg::from_gray(32'(wr_gray_s));
   assign wr_bin_s   = wr_bin_w[PW-1:0];
   assign level      = wr_bin_s - ptr_bin;
   assign empty      = (level == '0);
   assign half       = (level >= PW'(DEPTH / 2));
   assign attempt    = started && lock_s;
   assign take       = attempt && !empty;
   assign nxt_bin    = ptr_bin + 1'b1;
   assign nxt_gray_w = lbf_pkg::to_gray(32'(nxt_bin));

   always_ff @(posedge clk) begin
      if (rst) begin
         ptr_bin   <= '0;
         ptr_gray  <= '0;
         started   <= 1'b0;
         underflow <= 1'b0;
         valid     <= 1'b0;
      end else begin
         valid <= take;
         if (take) begin
            ptr_bin  <= nxt_bin;
            ptr_gray <= nxt_gray_w[PW-1:0];
         end
         if (!lock_s)   started <= 1'b0;
         else if (half) started <= 1'b1;
         if (attempt && empty) underflow <= 1'b1;
      end
   end
endmodule

// File: rtl/lbf_top.sv
module lbf_top #(
   parameter int WIDTH       = 20,
   parameter int DEPTH       = 64,
   parameter int SYNC_STAGES = 2
) (
   input  logic             wr_clk,
   input  logic             wr_rst,
   input  logic             rx_locked,
   input  logic             wr_valid,
   input  logic [WIDTH-1:0] wr_word,
   output logic             wr_full,
   output logic             wr_overflow,
   input  logic             rd_clk,
   input  logic             rd_rst,
   output logic [WIDTH-1:0] rd_word,
   output logic             rd_valid,
   output logic             rd_empty,
   output logic             rd_half,
   output logic             rd_underflow
);
   localparam int AW = $clog2(DEPTH);
   localparam int PW = AW + 1;

   if (DEPTH < 4 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("lbf_top: DEPTH must be a power of two, at least 4");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("lbf_top: WIDTH must be positive");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("lbf_top: SYNC_STAGES must be at least 2");
   end

   logic [PW-1:0] wr_ptr_bin, wr_ptr_gray, rd_ptr_bin, rd_ptr_gray;
   logic [PW-1:0] wr_gray_at_rd, rd_gray_at_wr;
   logic          wr_en, rd_take, lock_at_rd, rd_started;

   lbf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_w2r (
      .clk(rd_clk), .rst(rd_rst), .d(wr_ptr_gray), .q(wr_gray_at_rd));

   lbf_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync_r2w (
      .clk(wr_clk), .rst(wr_rst), .d(rd_ptr_gray), .q(rd_gray_at_wr));

   lbf_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sync_lock (
      .clk(rd_clk), .rst(rd_rst), .d(rx_locked), .q(lock_at_rd));

   lbf_wr_side #(.AW(AW)) u_wr (
      .clk(wr_clk), .rst(wr_rst), .locked(rx_locked), .valid(wr_valid),
      .rd_gray_s(rd_gray_at_wr), .ptr_bin(wr_ptr_bin), .ptr_gray(wr_ptr_gray),
      .we(wr_en), .full(wr_full), .overflow(wr_overflow));

   lbf_rd_side #(.AW(AW)) u_rd (
      .clk(rd_clk), .rst(rd_rst), .lock_s(lock_at_rd), .wr_gray_s(wr_gray_at_rd),
      .ptr_bin(rd_ptr_bin), .ptr_gray(rd_ptr_gray), .take(rd_take),
      .valid(rd_valid), .started(rd_started), .empty(rd_empty),
      .half(rd_half), .underflow(rd_underflow));

   lbf_store #(.WIDTH(WIDTH), .AW(AW)) u_store (
      .wclk(wr_clk), .we(wr_en), .waddr(wr_ptr_bin[AW-1:0]), .wdata(wr_word),
      .rclk(rd_clk), .re(rd_take), .raddr(rd_ptr_bin[AW-1:0]), .rdata(rd_word));
endmodule

// File: rtl/lbf_chk.sv
module lbf_chk #(
   parameter int PW = 7
) (
   input logic          wr_clk,
   input logic          wr_rst,
   input logic          rx_locked,
   input logic          wr_full,
   input logic          wr_overflow,
   input logic [PW-1:0] wr_ptr,
   input logic          rd_clk,
   input logic          rd_rst,
   input logic          rd_valid,
   input logic          rd_empty,
   input logic          rd_half,
   input logic          rd_underflow,
   input logic          started
);
   AST_NO_WRITE_UNLOCKED: assert property (@(posedge wr_clk) disable iff (wr_rst)
      !rx_locked |=> $stable(wr_ptr)); // R1
   AST_START_AT_HALF: assert property (@(posedge rd_clk) disable iff (rd_rst)
      $rose(started) |-> $past(rd_half)); // R2
   AST_POP_NOT_EMPTY: assert property (@(posedge rd_clk) disable iff (rd_rst)
      rd_valid |-> $past(!rd_empty)); // R3
   AST_IDLE_UNTIL_START: assert property (@(posedge rd_clk) disable iff (rd_rst)
      !started |=> !rd_valid); // R4
   AST_FULL_HOLDS_PTR: assert property (@(posedge wr_clk) disable iff (wr_rst)
      wr_full |=> $stable(wr_ptr)); // R5
   AST_OVF_STICKY: assert property (@(posedge wr_clk) disable iff (wr_rst)
      wr_overflow |=> wr_overflow); // R5
   AST_UNF_STICKY: assert property (@(posedge rd_clk) disable iff (rd_rst)
      rd_underflow |=> rd_underflow); // R6
endmodule

bind lbf_top lbf_chk #(.PW(PW)) chk_i (
   .wr_clk(wr_clk), .wr_rst(wr_rst), .rx_locked(rx_locked), .wr_full(wr_full),
   .wr_overflow(wr_overflow), .wr_ptr(wr_ptr_bin), .rd_clk(rd_clk), .rd_rst(rd_rst),
   .rd_valid(rd_valid), .rd_empty(rd_empty), .rd_half(rd_half),
   .rd_underflow(rd_underflow), .started(rd_started));

// File: tb/lbf_top_tb_top.sv
`timescale 1ns/1ps
module lbf_top_tb_top;
   localparam int WIDTH = 20;
   localparam int DEPTH = 8;
   localparam int HALF  = DEPTH / 2;

   logic             wr_clk = 1'b0, rd_clk = 1'b0;
   logic             wr_rst = 1'b1, rd_rst = 1'b1;
   logic             rx_locked = 1'b0, wr_valid = 1'b0;
   logic [WIDTH-1:0] wr_word = '0;
   logic             wr_full, wr_overflow;
   logic [WIDTH-1:0] rd_word;
   logic             rd_valid, rd_empty, rd_half, rd_underflow;

   int checks = 0, fails = 0;
   int rcv = 0, seq_err = 0;
   bit seq_on = 1'b1;
   logic [WIDTH-1:0] exp_next = '0;
   bit done = 1'b0;

   always #2 wr_clk = ~wr_clk;   // 250 MHz write clock
   always #7 rd_clk = ~rd_clk;   // slower read clock

   lbf_top #(.WIDTH(WIDTH), .DEPTH(DEPTH), .SYNC_STAGES(2)) dut_i (
      .wr_clk(wr_clk), .wr_rst(wr_rst), .rx_locked(rx_locked), .wr_valid(wr_valid),
      .wr_word(wr_word), .wr_full(wr_full), .wr_overflow(wr_overflow),
      .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_word(rd_word), .rd_valid(rd_valid),
      .rd_empty(rd_empty), .rd_half(rd_half), .rd_underflow(rd_underflow));

   always @(negedge rd_clk) begin
      if (rd_valid) begin
         rcv = rcv + 1;
         if (seq_on && rd_word !== exp_next) seq_err = seq_err + 1;
         exp_next = rd_word + 1'b1;
      end
   end

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic reset_all(input logic [WIDTH-1:0] base);
      rx_locked = 1'b0; wr_valid = 1'b0;
      wr_rst = 1'b1; rd_rst = 1'b1;
      repeat (4) @(negedge rd_clk);
      wr_rst = 1'b0; rd_rst = 1'b0;
      rcv = 0; seq_err = 0; exp_next = base; seq_on = 1'b1;
      repeat (2) @(negedge rd_clk);
   endtask

   task automatic burst(input int k, input logic [WIDTH-1:0] base);
      for (int i = 0; i < k; i++) begin
         @(negedge wr_clk);
         wr_valid = 1'b1;
         wr_word  = base + WIDTH'(i);
      end
      @(negedge wr_clk);
      wr_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge rd_clk);
   endtask

   initial begin
      logic [WIDTH-1:0] b;
      int r0;
      // R8 reset state
      reset_all('0);
      check("R8 rd_empty", int'(rd_empty), 1);
      check("R8 rd_half", int'(rd_half), 0);
      check("R8 wr_full", int'(wr_full), 0);
      check("R8 wr_overflow", int'(wr_overflow), 0);
      check("R8 rd_underflow", int'(rd_underflow), 0);
      check("R8 rd_valid", int'(rd_valid), 0);

      // R2 R3 R6 R7: sweep every burst length 0..DEPTH
      for (int k = 0; k <= DEPTH; k++) begin
         b = WIDTH'(32'h1_0000 + k * 32'h111);
         reset_all(b);
         rx_locked = 1'b1;
         burst(k, b);
         idle(25);
         check("R2 R3 words out", rcv, (k >= HALF) ? k : 0);
         check("R3 order", seq_err, 0);
         check("R6 underflow", int'(rd_underflow), (k >= HALF) ? 1 : 0);
         check("R7 empty", int'(rd_empty), (k == 0 || k >= HALF) ? 1 : 0);
         check("R7 half", int'(rd_half), 0);
         check("R5 no overflow", int'(wr_overflow), 0);
      end

      // R1: words offered while unlocked never enter
      reset_all(20'h0_0500);
      burst(6, 20'h0_0500);
      idle(20);
      check("R1 nothing out", rcv, 0);
      check("R1 still empty", int'(rd_empty), 1);

      // R4: lock loss clears the started state
      reset_all(20'h0_0A00);
      rx_locked = 1'b1;
      burst(HALF, 20'h0_0A00);
      idle(25);
      check("R4 first drain", rcv, HALF);
      rx_locked = 1'b0;
      idle(10);
      rx_locked = 1'b1;
      idle(5);
      burst(HALF - 1, 20'h0_0A00 + WIDTH'(HALF));
      idle(25);
      check("R4 held below half", rcv, HALF);
      check("R4 level kept", int'(rd_empty), 0);
      burst(1, 20'h0_0A00 + WIDTH'(2 * HALF - 1));
      idle(25);
      check("R4 resumed at half", rcv, 2 * HALF);
      check("R3 order after relock", seq_err, 0);

      // R5: overrun the store
      reset_all('0);
      seq_on = 1'b0;
      rx_locked = 1'b1;
      burst(40, 20'h0_2000);
      check("R5 overflow set", int'(wr_overflow), 1);
      r0 = rcv;
      rx_locked = 1'b0;
      idle(30);
      check("R5 overflow sticky", int'(wr_overflow), 1);
      check("R4 reads stop on unlock", (rcv - r0 <= 3) ? 1 : 0, 1);
      check("R4 valid low unlocked", int'(rd_valid), 0);

      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      #500000;
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule